// File: doc/BRIEF.md
# Sampled Change-of-State Detector

This block watches a group of general-purpose pins, two per channel, and records for each one whether its level has moved since the host last read that channel's change register. The pins are not examined on every clock. A free-running divider produces a sample strobe once every `SAMPLE_DIV` cycles. With the default of 96 and a 3.6864 MHz clock, that is about one sample every 26 µs. Changes shorter than a sample period may be missed, which filters out fast glitches at no cost. Before sampling, the pins pass through a synchronizer. Detection does not depend on whether the system drives a pin as an output or reads it as an input, so the block takes no direction information.

Each pin keeps three things: a sample register, a reference level and a sticky change flag. A flag is set when the sampled level differs from the reference. It stays set until the host reads that channel, even if the pin returns to its old level. A read returns the current sample levels together with the flags. The same read clears the flags and makes the reported level the new reference. The block also drives an interrupt request, formed from the flags and a per-pin enable mask, into a separate interrupt arbiter.

Top module: `pin_change_detect`

## Requirements
- R1: While reset is held and until the first sample strobe after reset, `rd_data_o` reads 0 for every channel and `irq_o` is low.
- R2: Pins are sampled once every `SAMPLE_DIV` clock cycles, after a synchronizer of `SYNC_STAGES` flops (default 2). Counting the clock edges after reset release as 1, 2, ..., samples are taken at edges SAMPLE_DIV, 2·SAMPLE_DIV, and so on. A pin level that is stable before edge e is captured by the first sample edge that is at or after e+2. Between samples, the reported levels do not change.
- R3: The first sample after reset loads the reference of every pin and sets no change flag.
- R4: A pin's change flag is set when its sampled level differs from its reference. The flag remains set until that channel is read, even if the pin returns to the reference level.
- R5: `rd_data_o` shows the channel selected by `rd_ch_i` in the same cycle, as {change1, change0, level1, level0} (bits 3..0). Channel n uses pins `pins_i[2n]` (pin 0) and `pins_i[2n+1]` (pin 1).
- R6: A cycle with `rd_i` high clears only the selected channel's change flags and makes its reported levels the new reference. Other channels keep their flags.
- R7: If a sample taken at the edge that ends a read cycle differs from the level reported by that read, the flag is set again for the next read.
- R8: `irq_o` is high exactly when some pin has its change flag set and its `mask_i` bit (same index as `pins_i`) is 1. It follows the mask without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 2*NUM_CH | Pin levels, two per channel |
| mask_i | input | 2*NUM_CH | Per-pin interrupt enable |
| rd_i | input | 1 | Host read of the change register of channel `rd_ch_i` |
| rd_ch_i | input | $clog2(NUM_CH) | Channel selected for reading |
| rd_data_o | output | 4 | {change1, change0, level1, level0} of the selected channel |
| irq_o | output | 1 | Change interrupt request to the arbiter |

## Verification
The hardest case to reach from the ports is a read that lands on the exact cycle of a sample strobe while the new sample differs from the level being reported. The bench reproduces the divider phase by counting edges from reset release. It changes a pin a few cycles before a strobe and raises the read during the strobe cycle, so the read reports the old level with a clear flag. A later read must then show the flag set again. The same phase counting places pin changes just before and just after the synchronizer cut-off, which pins down the sample period and the latency. Random pin patterns, masks and channel reads then exercise the sticky, per-channel clearing rules against a bench model.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    // levels of the two detected pins of one channel
    typedef logic [1:0] pair_t;

    // state held for one channel
    typedef struct packed {
        pair_t samp;   // most recent sample
        pair_t refv;   // level at last host read (or first sample)
        pair_t chg;    // sticky change flags
    } pair_state_t;

endpackage

// File: rtl/pcd_sample_timer.sv
module pcd_sample_timer #(
    parameter int SAMPLE_DIV = 96
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic strobe_o
);
    localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        strobe_o = (cnt_q == LAST);
        cnt_d    = strobe_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
        q_o = chain_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end
endmodule

// File: rtl/pcd_pair.sv
module pcd_pair
    import pcd_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  strobe_i,
    input  logic  prime_i,
    input  logic  clr_i,
    input  pair_t pins_i,
    output pair_t lvl_o,
    output pair_t chg_o
);
    pair_state_t st_d, st_q;
    pair_t       s_next;
    pair_t       ref_new;

    always_comb begin
        s_next  = strobe_i ? pins_i : st_q.samp;
        // a read makes the level it reports the new reference
        ref_new = clr_i ? st_q.samp : st_q.refv;

        st_d.samp = s_next;
        if (prime_i) begin
            st_d.refv = s_next;
            st_d.chg  = '0;
        end else begin
            st_d.refv = ref_new;
            st_d.chg  = (clr_i ? pair_t'('0) : st_q.chg) | (s_next ^ ref_new);
        end

        lvl_o = st_q.samp;
        chg_o = st_q.chg;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
    import pcd_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SAMPLE_DIV  = 96,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = 2 * NUM_CH,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [PIN_W-1:0] mask_i,
    input  logic             rd_i,
    input  logic [CH_W-1:0]  rd_ch_i,
    output logic [3:0]       rd_data_o,
    output logic             irq_o
);
    typedef struct packed {
        logic primed;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             sample_stb;
    logic             prime_stb;
    logic             primed_q;
    logic [PIN_W-1:0] pins_sync;
    logic [PIN_W-1:0] lvl_all;
    logic [PIN_W-1:0] chg_all;
    logic [NUM_CH-1:0] clr_ch;

    pcd_sample_timer #(.SAMPLE_DIV(SAMPLE_DIV)) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_o (sample_stb)
    );

    pcd_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_i),
        .q_o    (pins_sync)
    );

    always_comb begin
        st_d.primed = st_q.primed | sample_stb;
        prime_stb   = sample_stb & ~st_q.primed;
        primed_q    = st_q.primed;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign clr_ch[ch] = rd_i && (rd_ch_i == CH_W'(ch));

        pcd_pair pair_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .strobe_i (sample_stb),
            .prime_i  (prime_stb),
            .clr_i    (clr_ch[ch]),
            .pins_i   (pins_sync[2*ch +: 2]),
            .lvl_o    (lvl_all[2*ch +: 2]),
            .chg_o    (chg_all[2*ch +: 2])
        );
    end

    always_comb begin
        rd_data_o = {chg_all[{rd_ch_i, 1'b0} +: 2], lvl_all[{rd_ch_i, 1'b0} +: 2]};
        irq_o     = |(chg_all & mask_i);
    end
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int NUM_CH     = 4,
    parameter int SAMPLE_DIV = 96,
    localparam int PIN_W     = 2 * NUM_CH,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rd_i,
    input logic [CH_W-1:0]  rd_ch_i,
    input logic [PIN_W-1:0] mask_i,
    input logic             irq_o,
    input logic             strobe_i,
    input logic             primed_i,
    input logic [PIN_W-1:0] chg_i,
    input logic [PIN_W-1:0] lvl_i
);
    // independent period counter for the strobe window
    int unsigned ck_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          ck_cnt <= 0;
        else if (ck_cnt == SAMPLE_DIV - 1)    ck_cnt <= 0;
        else                                  ck_cnt <= ck_cnt + 1;
    end

    p_strobe_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |-> (ck_cnt == SAMPLE_DIV - 1));

    p_level_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> $stable(lvl_i));

    p_quiet_prime_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !primed_i |-> (chg_i == '0));

    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> ((chg_i & $past(chg_i)) == $past(chg_i)));

    p_clear_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !strobe_i) |=> (chg_i[{$past(rd_ch_i), 1'b0} +: 2] == 2'b00));

    p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(strobe_i) || !$stable(mask_i)));

    p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> ($past(rd_i) || !$stable(mask_i)));
endmodule

bind pin_change_detect pcd_checker #(.NUM_CH(NUM_CH), .SAMPLE_DIV(SAMPLE_DIV)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .rd_ch_i  (rd_ch_i),
    .mask_i   (mask_i),
    .irq_o    (irq_o),
    .strobe_i (sample_stb),
    .primed_i (primed_q),
    .chg_i    (chg_all),
    .lvl_i    (lvl_all)
);

// File: tb/pin_change_detect_tb_top.sv
module pin_change_detect_tb_top;
    localparam int NUM_CH = 4;
    localparam int DIV    = 96;
    localparam int PIN_W  = 2 * NUM_CH;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SETTLE = 2 * DIV + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIN_W-1:0] pins = '0;
    logic [PIN_W-1:0] mask = '0;
    logic             rd = 1'b0;
    logic [CH_W-1:0]  rd_ch = '0;
    logic [3:0]       rd_data;
    logic             irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;
    int cyc;

    // model state
    logic [PIN_W-1:0] m_lvl = '0, m_ref = '0, m_chg = '0;

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    pin_change_detect #(.NUM_CH(NUM_CH), .SAMPLE_DIV(DIV)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pins_i    (pins),
        .mask_i    (mask),
        .rd_i      (rd),
        .rd_ch_i   (rd_ch),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_chg & mask);
    endfunction

    function automatic logic [3:0] exp_rd(int ch);
        return {m_chg[2*ch +: 2], m_lvl[2*ch +: 2]};
    endfunction

    // model: the current pins have been sampled
    task automatic settle_model();
        m_lvl = pins;
        m_chg = m_chg | (m_lvl ^ m_ref);
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mod(int r);
        do @(negedge clk); while ((cyc % DIV) != r);
    endtask

    // called at a negedge; read occupies one cycle
    task automatic do_read(int ch, string req);
        rd_ch = CH_W'(ch);
        rd    = 1'b1;
        #1;
        check(req, rd_data, exp_rd(ch));
        m_ref[2*ch +: 2] = m_lvl[2*ch +: 2];
        m_chg[2*ch +: 2] = 2'b00;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NUM_CH; c++) do_read(c, "R6 clear");
    endtask

    initial begin
        logic [3:0] old;
        void'($urandom(32'h5EED_1234));
        pins = 8'hA5;
        mask = '1;
        wait_cycles(3);
        rst_n = 1'b1;
        // R1: before the first strobe nothing is reported
        wait_cycles(2);
        check("R1 rd_data after reset", rd_data, 4'h0);
        check("R1 irq after reset", irq, 1'b0);

        // R3: first sample primes the reference, no flags
        wait_cycles(SETTLE);
        m_lvl = pins; m_ref = pins; m_chg = '0;
        check("R3 no irq after first sample", irq, 1'b0);
        for (int c = 0; c < NUM_CH; c++) do_read(c, "R3/R5 read after prime");

        // R2: exact sample timing and sync depth
        mask = 8'h01;
        wait_mod(2);
        pins[0] = ~pins[0];
        wait_mod(DIV - 1);
        check("R2 not sampled before period edge", irq, 1'b0);
        @(negedge clk);
        check("R2 sampled at period edge", irq, 1'b1);
        settle_model();
        do_read(0, "R5 read ch0 after R2");
        wait_mod(DIV - 2);
        pins[0] = ~pins[0];
        wait_mod(0);
        check("R2 late change misses sample", irq, 1'b0);
        wait_mod(0);
        check("R2 late change caught next sample", irq, 1'b1);
        settle_model();
        mask = '1;
        clear_all();

        // R4: sticky after pin returns
        pins[3] = ~pins[3];
        wait_cycles(SETTLE);
        settle_model();
        pins[3] = ~pins[3];
        wait_cycles(SETTLE);
        settle_model();
        check("R4 flag stays after return", irq, 1'b1);
        check("R4 model flag set", m_chg[3], 1'b1);
        do_read(1, "R4 sticky read ch1");

        // R6: other channel untouched by a read
        pins[0] = ~pins[0];
        pins[5] = ~pins[5];
        wait_cycles(SETTLE);
        settle_model();
        do_read(0, "R6 read ch0");
        check("R6 irq kept by ch2", irq, 1'b1);
        do_read(2, "R6 ch2 flag survived");
        check("R6 irq low after both reads", irq, 1'b0);

        // R7: change sampled on the read cycle
        wait_mod(DIV - 4);
        pins[2] = ~pins[2];
        wait_mod(DIV - 1);
        old = {2'b00, m_lvl[3:2]};
        rd_ch = 2'd1;
        rd = 1'b1;
        #1;
        check("R7 read on strobe shows old level", rd_data, old);
        @(negedge clk);
        rd = 1'b0;
        m_ref[3:2] = m_lvl[3:2];
        m_chg[3:2] = 2'b00;
        settle_model();
        check("R7 irq re-raised", irq, 1'b1);
        do_read(1, "R7 flag set again");

        // R8: mask gating, combinational
        pins[6] = ~pins[6];
        wait_cycles(SETTLE);
        settle_model();
        mask = 8'hBF;
        #1;
        check("R8 masked flag gives no irq", irq, 1'b0);
        mask = 8'h40;
        #1;
        check("R8 unmasked flag gives irq", irq, 1'b1);
        mask = '1;
        clear_all();

        // random mix
        for (int it = 0; it < 150; it++) begin
            logic [PIN_W-1:0] flip;
            flip = PIN_W'($urandom) & PIN_W'($urandom);
            pins = pins ^ flip;
            wait_cycles(SETTLE);
            settle_model();
            mask = PIN_W'($urandom);
            #1;
            check("R8 random irq", irq, exp_irq());
            if ($urandom_range(0, 1) == 1) begin
                int c;
                c = $urandom_range(0, NUM_CH - 1);
                do_read(c, "R4/R5/R6 random read");
            end
        end
        for (int c = 0; c < NUM_CH; c++) do_read(c, "R5 final read");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule